// File: doc/BRIEF.md
# Mask-Driven Bit Partition Network

This block splits an 8-bit data word into two groups that are chosen by an 8-bit select mask. Every data bit whose mask bit is set goes to the upper half of the result. Every data bit whose mask bit is clear goes to the lower half. Inside each half, the bits keep the left-to-right order they had in the input word. A usable mask holds exactly four ones. Any other mask raises an error flag and zeroes the result.

There is no lookup table and no fixed wiring. Each output position picks its bit from a five-way candidate set. Output position k of the upper half can only be reached by the k-th set mask bit counted from the top, so it has five possible sources. The lower half works the same way, ranking the clear mask bits from bit 0 upward. A rank decoder turns the mask into a one-hot select for each output position. The packed word and the error flag are captured in registers with a synchronous active-high reset. The outputs therefore show the inputs that were present at the previous rising clock edge.

Top module: `bit_partition_net`

## Requirements
- R1: While `rst` is high at a rising edge, `result` and `mask_err` are cleared to 0 at that edge. The first edge after reset is released therefore still shows both at 0.
- R2: When the mask holds exactly four ones, the data bit at the k-th set mask bit counted from bit 7 (k = 0..3) appears at `result[7-k]`.
- R3: When the mask holds exactly four ones, the data bit at the k-th clear mask bit counted from bit 0 (k = 0..3) appears at `result[k]`.
- R4: Take data = 8'hB2 and mask = 8'hAA (ones at bits 7, 5, 3 and 1). The result is 8'hD4: upper nibble taken from bits 7, 5, 3, 1 and lower nibble from bits 6, 4, 2, 0, both in input order.
- R5: Mask 8'hF0 passes the data unchanged. Mask 8'h0F swaps the two nibbles of the data.
- R6: `mask_err` is 1 exactly when the number of ones in the mask is not four.
- R7: While `mask_err` is 1, `result` is 8'h00, whatever the data.
- R8: `result` and `mask_err` change only at a rising clock edge. Both reflect the `data_in` and `mask_in` values sampled at that edge, one cycle after those inputs were applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 8 | Word whose bits are partitioned |
| mask_in | input | 8 | Select mask; 1 = upper group, 0 = lower group |
| result | output | 8 | Registered packed word |
| mask_err | output | 1 | Registered flag: mask population is not four |

## Verification
Every one of the 70 valid masks is driven with four kinds of data, each of which exposes a different fault:
- Data equal to the mask must always give 8'hF0. This shows that every bit reached the correct half.
- Data equal to the inverted mask must always give 8'h0F, for the same reason.
- Random data and its complement show whether the order inside each half is correct. They also catch a wrong candidate tap, which group-only patterns cannot detect.

The fixed example and the two contiguous masks (8'hF0, 8'h0F) pin down the exact bit placement. Masks with zero, three, five and eight ones, each paired with all-ones data, show that the error flag and the zeroing both work.

// File: rtl/bpn_pkg.sv
package bpn_pkg;

  localparam int unsigned BPN_DEF_W = 8;
  localparam int unsigned BPN_VEC_W = 64;

  // Number of bits equal to val in v[hi-1:lo]; empty range gives 0.
  function automatic int unsigned bpn_count(input logic [BPN_VEC_W-1:0] v,
                                            input int unsigned lo,
                                            input int unsigned hi,
                                            input logic val);
    int unsigned n;
    n = 0;
    for (int unsigned i = 0; i < BPN_VEC_W; i++) begin
      if (i >= lo && i < hi && v[i] == val) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/bpn_rank_decode.sv
module bpn_rank_decode
  import bpn_pkg::*;
#(
  parameter int unsigned W         = BPN_DEF_W,
  parameter bit          FIND_ONES = 1'b1,
  localparam int unsigned HALF     = W / 2,
  localparam int unsigned SPAN     = HALF + 1
) (
  input  logic [W-1:0]                  mask,
  output logic [HALF-1:0][SPAN-1:0]     sel
);

  logic [BPN_VEC_W-1:0] mask_ext;
  assign mask_ext = {{(BPN_VEC_W-W){1'b0}}, mask};

  // Row k, candidate j: the mask position that would hold the k-th
  // ranked bit if it sits j places away from its earliest possible slot.
  for (genvar k = 0; k < HALF; k++) begin : g_rank
    for (genvar j = 0; j < SPAN; j++) begin : g_cand
      if (FIND_ONES) begin : g_ones
        localparam int unsigned P = W - 1 - k - j;
        always_comb begin
          sel[k][j] = mask[P] &&
                      (bpn_count(mask_ext, P + 1, W, 1'b1) == k);
        end
      end else begin : g_zeros
        localparam int unsigned P = k + j;
        always_comb begin
          sel[k][j] = !mask[P] &&
                      (bpn_count(mask_ext, 0, P, 1'b0) == k);
        end
      end
    end
  end

endmodule

// File: rtl/bpn_lane_mux.sv
module bpn_lane_mux
  import bpn_pkg::*;
#(
  parameter int unsigned W         = BPN_DEF_W,
  parameter bit          FIND_ONES = 1'b1,
  localparam int unsigned HALF     = W / 2,
  localparam int unsigned SPAN     = HALF + 1
) (
  input  logic [W-1:0]              data,
  input  logic [HALF-1:0][SPAN-1:0] sel,
  output logic [HALF-1:0]           lane
);

  // AND-OR selector: one-hot select rows make this a plain 5:1 mux.
  for (genvar k = 0; k < HALF; k++) begin : g_lane
    logic [SPAN-1:0] terms;
    for (genvar j = 0; j < SPAN; j++) begin : g_tap
      localparam int unsigned P = FIND_ONES ? (W - 1 - k - j) : (k + j);
      assign terms[j] = sel[k][j] & data[P];
    end
    assign lane[k] = |terms;
  end

endmodule

// File: rtl/bpn_pop_check.sv
module bpn_pop_check
  import bpn_pkg::*;
#(
  parameter int unsigned W = BPN_DEF_W
) (
  input  logic [W-1:0] mask,
  output logic         ok
);

  logic [BPN_VEC_W-1:0] mask_ext;
  assign mask_ext = {{(BPN_VEC_W-W){1'b0}}, mask};

  always_comb begin
    ok = (bpn_count(mask_ext, 0, W, 1'b1) == W / 2);
  end

endmodule

// File: rtl/bit_partition_net.sv
module bit_partition_net
  import bpn_pkg::*;
#(
  parameter int unsigned W = BPN_DEF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] data_in,
  input  logic [W-1:0] mask_in,
  output logic [W-1:0] result,
  output logic         mask_err
);

  localparam int unsigned HALF = W / 2;
  localparam int unsigned SPAN = HALF + 1;

  logic [HALF-1:0][SPAN-1:0] up_sel;
  logic [HALF-1:0][SPAN-1:0] lo_sel;
  logic [HALF-1:0]           up_lane;
  logic [HALF-1:0]           lo_lane;
  logic                      pop_ok;
  logic [W-1:0]              packed_c;
  logic                      primed;

  bpn_rank_decode #(.W(W), .FIND_ONES(1'b1)) u_dec_up (
    .mask (mask_in),
    .sel  (up_sel)
  );

  bpn_rank_decode #(.W(W), .FIND_ONES(1'b0)) u_dec_lo (
    .mask (mask_in),
    .sel  (lo_sel)
  );

  bpn_lane_mux #(.W(W), .FIND_ONES(1'b1)) u_mux_up (
    .data (data_in),
    .sel  (up_sel),
    .lane (up_lane)
  );

  bpn_lane_mux #(.W(W), .FIND_ONES(1'b0)) u_mux_lo (
    .data (data_in),
    .sel  (lo_sel),
    .lane (lo_lane)
  );

  bpn_pop_check #(.W(W)) u_pop (
    .mask (mask_in),
    .ok   (pop_ok)
  );

  // Upper lanes fill from the MSB downward, lower lanes from the LSB up.
  always_comb begin
    packed_c = '0;
    for (int k = 0; k < HALF; k++) begin
      packed_c[W-1-k] = up_lane[k];
      packed_c[k]     = lo_lane[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      mask_err <= 1'b0;
      primed   <= 1'b0;
    end else begin
      result   <= pop_ok ? packed_c : '0;
      mask_err <= !pop_ok;
      primed   <= 1'b1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (result == '0 && !mask_err)); // R1

  AST_ERR_TRACKS_POP: assert property (@(posedge clk) disable iff (rst)
    primed |-> (mask_err == ($countones($past(mask_in)) != HALF))); // R6

  AST_ZERO_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    mask_err |-> (result == '0)); // R7

  AST_UPPER_WEIGHT: assert property (@(posedge clk) disable iff (rst)
    (primed && !mask_err) |->
      ($countones(result[W-1:HALF]) == $countones($past(data_in & mask_in)))); // R2

  AST_LOWER_WEIGHT: assert property (@(posedge clk) disable iff (rst)
    (primed && !mask_err) |->
      ($countones(result[HALF-1:0]) == $countones($past(data_in & ~mask_in)))); // R3

  for (genvar k = 0; k < HALF; k++) begin : g_sel_chk
    AST_UP_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      pop_ok |-> $onehot(up_sel[k])); // R2
    AST_LO_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      pop_ok |-> $onehot(lo_sel[k])); // R3
  end

endmodule

// File: tb/bit_partition_net_test.sv
`timescale 1ns/1ps
module bit_partition_net_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] data_in = 8'h00;
  logic [7:0] mask_in = 8'h00;
  logic [7:0] result;
  logic       mask_err;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bit_partition_net uut (
    .clk      (clk),
    .rst      (rst),
    .data_in  (data_in),
    .mask_in  (mask_in),
    .result   (result),
    .mask_err (mask_err)
  );

  // Behavioural reference: two queues filled in scan order.
  function automatic logic [8:0] ref_model(input logic [7:0] d, input logic [7:0] m);
    bit hi_q[$];
    bit lo_q[$];
    logic [7:0] r;
    r = 8'h00;
    if ($countones(m) != 4) return {1'b1, 8'h00};
    for (int i = 7; i >= 0; i--) if (m[i]) hi_q.push_back(d[i]);
    for (int i = 0; i < 8; i++) if (!m[i]) lo_q.push_back(d[i]);
    for (int k = 0; k < 4; k++) begin
      r[7-k] = hi_q[k];
      r[k]   = lo_q[k];
    end
    return {1'b0, r};
  endfunction

  task automatic check(input string req, input logic [7:0] exp_r, input logic exp_e);
    n_cmp++;
    if (result !== exp_r || mask_err !== exp_e) begin
      n_fail++;
      $display("FAIL %s: data=%h mask=%h got result=%h err=%b, expected result=%h err=%b",
               req, data_in, mask_in, result, mask_err, exp_r, exp_e);
    end
  endtask

  // Drive on the falling edge; the next falling edge follows one rising edge.
  task automatic apply(input string req, input logic [7:0] d, input logic [7:0] m);
    logic [8:0] exp_v;
    data_in = d;
    mask_in = m;
    exp_v   = ref_model(d, m);
    @(negedge clk);
    check(req, exp_v[7:0], exp_v[8]);
  endtask

  initial begin
    logic [7:0] rnd;
    logic [7:0] prev_r;
    @(negedge clk);
    data_in = 8'hFF;
    mask_in = 8'hF0;
    @(negedge clk);
    check("R1 reset", 8'h00, 1'b0);
    rst = 1'b0;

    // R4 worked example
    apply("R4 example", 8'hB2, 8'hAA);
    if (result !== 8'hD4) begin
      n_fail++;
      $display("FAIL R4: got %h expected d4", result);
    end
    n_cmp++;

    // R5 contiguous masks
    apply("R5 identity", 8'h9C, 8'hF0);
    if (result !== 8'h9C) begin n_fail++; $display("FAIL R5: got %h expected 9c", result); end
    n_cmp++;
    apply("R5 swap", 8'h9C, 8'h0F);
    if (result !== 8'hC9) begin n_fail++; $display("FAIL R5: got %h expected c9", result); end
    n_cmp++;

    // R8: output holds between edges and follows the input after one edge
    data_in = 8'h5A;
    mask_in = 8'h33;
    prev_r  = result;
    #5;
    n_cmp++;
    if (result !== prev_r) begin
      n_fail++;
      $display("FAIL R8: result moved before edge, got %h expected %h", result, prev_r);
    end
    @(negedge clk);
    begin
      logic [8:0] e8;
      e8 = ref_model(8'h5A, 8'h33);
      check("R8 one-cycle latency", e8[7:0], e8[8]);
    end

    // R2/R3 sweep of all valid masks
    for (int m = 0; m < 256; m++) begin
      if ($countones(m[7:0]) == 4) begin
        rnd = $urandom();
        apply("R2 group by mask", m[7:0], m[7:0]);
        apply("R3 group by inverse", ~m[7:0], m[7:0]);
        apply("R2/R3 order random", rnd, m[7:0]);
        apply("R2/R3 order complement", ~rnd, m[7:0]);
      end
    end

    // R6/R7 invalid masks
    apply("R6 R7 pop0", 8'hFF, 8'h00);
    apply("R6 R7 pop8", 8'hFF, 8'hFF);
    apply("R6 R7 pop3", 8'hFF, 8'h07);
    apply("R6 R7 pop5", 8'hFF, 8'h1F);
    apply("R6 recovery", 8'hB2, 8'hAA);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_cmp++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

endmodule